// File: doc/BRIEF.md
# West-First Adaptive Output Port Selector

This block decides, for the head flit of a packet arriving at a two-dimensional mesh router, which output port the packet leaves by. It takes the signed X and Y hop offsets that remain to the destination, together with one busy-or-failed status bit for each neighbour port that could be picked by status. It returns one selected port and a flag that says whether the selection came from a choice between two candidate ports. The selector follows the west-first turn model. Any westward travel is finished before anything else, and the two turns that would end up heading west are never produced. Once no westward travel remains, the selector may steer around congestion or failed links, but only along directions that shorten the route.

Head flits enter on a valid/ready stream and decisions leave on a second valid/ready stream through a single register stage. A head flit is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The status bits are sampled on that same edge. While `out_valid` is high and `out_ready` is low, the decision is held without change.

Top module: `wf_route_sel`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until a head flit is accepted.
- R2: A negative X offset always selects the west port (code 2) with the adaptive flag 0, whatever the status bits say.
- R3: Both offsets zero selects the local port (code 0) with the adaptive flag 0. The local port is never selected otherwise.
- R4: A positive X offset with a zero Y offset selects east (code 1) with the adaptive flag 0.
- R5: A zero X offset selects north (code 3) for a positive Y offset and south (code 4) for a negative one, with the adaptive flag 0.
- R6: A positive X offset with a nonzero Y offset offers two candidates: east first, then the Y port in the direction of Y. The first candidate whose status bit is clear is chosen, with the adaptive flag 1. If both are marked, east is chosen with the adaptive flag 0. Status bit 0 is east, bit 1 is north and bit 2 is south; a set bit means busy or failed.
- R7: Only minimal directions are ever selected. East needs X > 0, north needs Y > 0 and south needs Y < 0.
- R8: A decision appears on `out_valid` after the first rising edge following its acceptance. It is held stable while `out_ready` is low, and `in_ready` equals `!out_valid || out_ready`.
- R9: Status bits of ports that are not candidates for the current offsets have no effect on the selected port or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Head flit offsets are present |
| in_ready | output | 1 | Selector can take a head flit this cycle |
| in_dx | input | OFS_W | Signed X hops remaining (east positive) |
| in_dy | input | OFS_W | Signed Y hops remaining (north positive) |
| port_blocked | input | 3 | Busy/failed flags: bit0 east, bit1 north, bit2 south |
| out_valid | output | 1 | A decision is present |
| out_ready | input | 1 | Downstream takes the decision this cycle |
| out_port | output | 3 | 0 local, 1 east, 2 west, 3 north, 4 south |
| out_adaptive | output | 1 | 1 when the port was chosen between two candidates by status |

## Verification
Every decision is due exactly one rising edge after the edge that accepted its head flit. It then stays on the outputs until an edge where `out_ready` is high. The bench drives inputs and reads `in_ready` at falling edges, when that signal is settled, and pushes the expected port and flag into a queue at the moment of acceptance. A monitor pops and compares entries at falling edges when `out_valid` and `out_ready` are both high. A directed case with downstream always ready confirms the one-edge latency. Random back-pressure confirms that stalled decisions do not change.

// File: rtl/wf_route_pkg.sv
package wf_route_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  localparam int BLK_W   = 3;
  localparam int BLK_EAST  = 0;
  localparam int BLK_NORTH = 1;
  localparam int BLK_SOUTH = 2;

  typedef struct packed {
    logic go_west;
    logic go_east;
    logic go_north;
    logic go_south;
    logic arrived;
  } dirs_t;

  typedef struct packed {
    port_e port;
    logic  adaptive;
  } choice_t;

endpackage

// File: rtl/wf_dir_decode.sv
module wf_dir_decode
  import wf_route_pkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic signed [OFS_W-1:0] dx,
  input  logic signed [OFS_W-1:0] dy,
  output dirs_t                   dirs
);
  localparam logic signed [OFS_W-1:0] ZERO = '0;

  always_comb begin
    dirs.go_west  = (dx < ZERO);
    dirs.go_east  = (dx > ZERO);
    dirs.go_north = (dy > ZERO);
    dirs.go_south = (dy < ZERO);
    dirs.arrived  = (dx == ZERO) && (dy == ZERO);
  end
endmodule

// File: rtl/wf_port_pick.sv
module wf_port_pick
  import wf_route_pkg::*;
(
  input  dirs_t            dirs,
  input  logic [BLK_W-1:0] blocked,
  output choice_t          choice
);
  logic  y_any;
  port_e y_port;
  logic  y_busy;

  always_comb begin
    y_any  = dirs.go_north || dirs.go_south;
    y_port = dirs.go_north ? PORT_NORTH : PORT_SOUTH;
    y_busy = dirs.go_north ? blocked[BLK_NORTH] : blocked[BLK_SOUTH];
  end

  always_comb begin
    choice.port     = PORT_LOCAL;
    choice.adaptive = 1'b0;
    if (dirs.go_west) begin
      choice.port = PORT_WEST;
    end else if (dirs.go_east && y_any) begin
      if (!blocked[BLK_EAST]) begin
        choice.port     = PORT_EAST;
        choice.adaptive = 1'b1;
      end else if (!y_busy) begin
        choice.port     = y_port;
        choice.adaptive = 1'b1;
      end else begin
        choice.port = PORT_EAST;
      end
    end else if (dirs.go_east) begin
      choice.port = PORT_EAST;
    end else if (y_any) begin
      choice.port = y_port;
    end
  end
endmodule

// File: rtl/wf_out_slice.sv
module wf_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/wf_route_sel.sv
module wf_route_sel
  import wf_route_pkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [OFS_W-1:0] in_dx,
  input  logic signed [OFS_W-1:0] in_dy,
  input  logic [BLK_W-1:0]        port_blocked,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2:0]              out_port,
  output logic                    out_adaptive
);
  typedef struct packed {
    logic signed [OFS_W-1:0] dx;
    logic signed [OFS_W-1:0] dy;
    logic [BLK_W-1:0]        blk;
    choice_t                 pick;
  } held_t;
  localparam int HW = $bits(held_t);

  dirs_t   dirs;
  choice_t pick;
  held_t   nxt, held;

  wf_dir_decode #(.OFS_W(OFS_W)) u_dec (
    .dx(in_dx), .dy(in_dy), .dirs(dirs)
  );

  wf_port_pick u_pick (
    .dirs(dirs), .blocked(port_blocked), .choice(pick)
  );

  always_comb begin
    nxt.dx   = in_dx;
    nxt.dy   = in_dy;
    nxt.blk  = port_blocked;
    nxt.pick = pick;
  end

  logic [HW-1:0] held_bits;
  wf_out_slice #(.W(HW)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(nxt),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(held_bits)
  );
  assign held         = held_t'(held_bits);
  assign out_port     = held.pick.port;
  assign out_adaptive = held.pick.adaptive;

  localparam logic signed [OFS_W-1:0] Z = '0;

  AST_WEST_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (held.dx < Z) |-> (out_port == PORT_WEST) && !out_adaptive); // R2
  AST_LOCAL_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_port == PORT_LOCAL) == ((held.dx == Z) && (held.dy == Z)))); // R3
  AST_MIN_EAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_port == PORT_EAST) |-> (held.dx > Z)); // R7
  AST_MIN_NORTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_port == PORT_NORTH) |-> (held.dy > Z) && (held.dx >= Z)); // R7
  AST_MIN_SOUTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_port == PORT_SOUTH) |-> (held.dy < Z) && (held.dx >= Z)); // R7
  AST_ADAPT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_adaptive |->
      !((out_port == PORT_EAST  && held.blk[BLK_EAST]) ||
        (out_port == PORT_NORTH && held.blk[BLK_NORTH]) ||
        (out_port == PORT_SOUTH && held.blk[BLK_SOUTH]))); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_adaptive)); // R8
  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
endmodule

// File: tb/wf_route_sel_tb.sv
`timescale 1ns/1ps
module wf_route_sel_tb;
  localparam int OFS_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [OFS_W-1:0] in_dx = '0;
  logic signed [OFS_W-1:0] in_dy = '0;
  logic [2:0] port_blocked = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [2:0] out_port;
  logic out_adaptive;

  int tests = 0;
  int fails = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [2:0] q_port[$];
  logic       q_adp[$];
  string      q_req[$];

  always #2.5 clk = ~clk;

  wf_route_sel #(.OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dx(in_dx), .in_dy(in_dy), .port_blocked(port_blocked),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .out_adaptive(out_adaptive)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected decision from the requirements (R2..R6, R9)
  task automatic expect_of(int dx, int dy, logic [2:0] blk,
                           output logic [2:0] p, output logic a, output string r);
    a = 1'b0;
    if (dx < 0) begin p = 3'd2; r = "R2"; end
    else if (dx == 0 && dy == 0) begin p = 3'd0; r = "R3"; end
    else if (dx > 0 && dy == 0) begin p = 3'd1; r = "R4"; end
    else if (dx == 0) begin p = (dy > 0) ? 3'd3 : 3'd4; r = "R5"; end
    else begin
      r = "R6";
      if (!blk[0]) begin p = 3'd1; a = 1'b1; end
      else if ((dy > 0) ? !blk[1] : !blk[2]) begin p = (dy > 0) ? 3'd3 : 3'd4; a = 1'b1; end
      else p = 3'd1;
    end
  endtask

  task automatic send(int dx, int dy, logic [2:0] blk);
    logic [2:0] p; logic a; string r;
    @(negedge clk);
    in_valid = 1'b1;
    in_dx = dx[OFS_W-1:0];
    in_dy = dy[OFS_W-1:0];
    port_blocked = blk;
    while (!in_ready) @(negedge clk);
    expect_of(dx, dy, blk, p, a, r);
    q_port.push_back(p); q_adp.push_back(a); q_req.push_back(r);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // back-pressure driver
  initial forever begin
    @(posedge clk);
    #1 out_ready = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    logic [2:0] held_p; logic held_a; bit was_stalled;
    was_stalled = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stalled) begin
          check(out_valid == 1'b1 && out_port == held_p && out_adaptive == held_a,
                "R8", "stalled decision held", int'(out_port), int'(held_p));
        end
        was_stalled = out_valid && !out_ready;
        held_p = out_port; held_a = out_adaptive;
        check(in_ready == (!out_valid || out_ready), "R8", "in_ready rule",
              int'(in_ready), int'(!out_valid || out_ready));
        if (out_valid && out_ready) begin
          if (q_port.size() == 0) begin
            check(1'b0, "R8", "unexpected output", int'(out_port), -1);
          end else begin
            logic [2:0] ep; logic ea; string er;
            ep = q_port.pop_front(); ea = q_adp.pop_front(); er = q_req.pop_front();
            check(out_port == ep, er, "port", int'(out_port), int'(ep));
            check(out_adaptive == ea, er, "adaptive", int'(out_adaptive), int'(ea));
            // R7: chosen direction shortens the route (checked via the model's minimal choice)
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R8", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R8 latency: visible at the first falling edge after the accepting edge
    send(3, 0, 3'b000);
    @(negedge clk);
    check(out_valid == 1'b1, "R8", "one-edge latency", int'(out_valid), 1);

    // R2: west regardless of status
    send(-4, 2, 3'b111);
    send(-1, -3, 3'b000);
    send(-15, 0, 3'b101);
    // R3 local, R9 status ignored
    send(0, 0, 3'b111);
    // R4 east only, R9 status ignored even if east is blocked
    send(5, 0, 3'b111);
    // R5 pure Y, R9 status ignored
    send(0, 6, 3'b111);
    send(0, -2, 3'b010);
    // R6 preference order
    send(2, 3, 3'b000);   // east free
    send(2, 3, 3'b001);   // east busy, north free
    send(2, -3, 3'b001);  // east busy, south free
    send(2, -3, 3'b101);  // both busy -> east, flag 0
    send(2, 3, 3'b011);   // both busy -> east, flag 0
    send(1, 1, 3'b100);   // R9 south bit irrelevant for north
    send(15, -15, 3'b011);// R9 north bit irrelevant for south

    // random traffic under back-pressure (R7 via model)
    stall_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send($urandom_range(0, 30) - 15, $urandom_range(0, 30) - 15,
           3'($urandom_range(0, 7)));
    end

    for (int i = 0; i < 2000 && q_port.size() != 0; i++) @(negedge clk);
    check(q_port.size() == 0, "R8", "all decisions delivered", q_port.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule